// File: doc/BRIEF.md
# Tuner Status Read Port (I2C Slave)

This block is the read-only side of a serial control port for a tuner frequency synthesizer. It samples a bit-level I2C bus (SCL plus an open-drain SDA line) with the system clock and recognises its own 7-bit slave address. The upper five address bits are fixed. The lower two come from a 2-bit select input, which is the digitised result of an external address-select level detector. When a read addressed to the block arrives, the block acknowledges it and returns a status byte.

The status byte reports four things: a power-up flag, the synthesizer's lock indication, the state of the automatic charge-pump current switch, and a 3-bit converter code. The power-up flag is set by reset. It clears only when a read finishes without a master acknowledge. A master that acknowledges a byte receives a new byte built from fresh input samples. SDA is driven only by pulling it low (`sdaPullLow`), and the bus line is read back on `sdaIn`.

Top module: `tuner_status_reader`

## Requirements
- R1: A START followed by the address byte `{5'b11000, addrSel[1], addrSel[0], 1}` (MSB first, last bit = read) is acknowledged: the block pulls SDA low for the whole ninth SCL clock.
- R2: An address byte whose upper seven bits do not match, or whose last bit is 0, gets no acknowledge. SDA stays released (all bits read as 1) for the rest of that transfer.
- R3: Status bits are sent MSB first. The block starts pulling SDA low only while SCL is low.
- R4: Status byte layout, bit 7 down to bit 0: power-up flag, lock flag (= `inLock`), charge-pump flag, constant 1, constant 0, `adcCode[2:0]`.
- R5: The charge-pump flag (bit 5) is 0 exactly when `autoMode` and `inLock` are both 1, and is 1 otherwise.
- R6: The power-up flag reads 1 after reset. It becomes 0 once a status byte is not acknowledged by the master, and stays 0 until the next reset. An acknowledged byte or a STOP does not clear it.
- R7: When the master acknowledges a status byte, a further byte follows. Its content is sampled at the SCL falling edge that ends the acknowledge bit.
- R8: After a status byte without master acknowledge, the block releases SDA and ignores the bus until the next START.
- R9: A START at any point restarts address reception. A STOP at any point returns the block to idle, so address bits sent afterwards without a START are not acknowledged.
- R10: Each of the four `addrSel` codes selects a distinct address. Bit 1 of the select code is address bit 1 and bit 0 is address bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rstN | input | 1 | Active-low reset, power-up |
| scl | input | 1 | I2C clock line |
| sdaIn | input | 1 | I2C data line as seen on the bus |
| sdaPullLow | output | 1 | 1 pulls SDA low, 0 releases it |
| addrSel | input | 2 | Low two bits of the slave address |
| inLock | input | 1 | Synthesizer loop locked |
| autoMode | input | 1 | Automatic charge-pump switching enabled |
| adcCode | input | 3 | Converter result reported in the status byte |

## Verification
The bench builds the block with its default parameters: a two-stage input synchronizer, base address 11000 and a 3-bit converter code. With these small settings every combination can be swept. All four select codes are tried against all four low-address patterns, with both directions. All 32 combinations of converter code, lock and auto mode are read back. The bench also covers multi-byte reads with inputs changed between bytes, the flag surviving a STOP, and aborts by repeated START and by STOP.

// File: rtl/tuner_rd_pkg.sv
package tuner_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_PREACK, ST_ACK, ST_SEND, ST_MACK, ST_RELOAD
  } rdState_t;

  typedef struct packed {
    logic load;
    logic shift;
    logic clrPor;
  } dpStrobe_t;
endpackage

// File: rtl/tuner_rd_sync.sv
module tuner_rd_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= '1;
      else if (s == 0) chain[s] <= asyncIn;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/tuner_rd_ctrl.sv
module tuner_rd_ctrl
  import tuner_rd_pkg::*;
#(
  parameter logic [4:0] BASE_ADDR = 5'b11000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclS,
  input  logic       sdaS,
  input  logic [1:0] addrSel,
  input  logic       bitOut,
  output dpStrobe_t  strb,
  output logic       sdaPullLow
);
  rdState_t   state;
  logic       sclD, sdaD;
  logic [2:0] bitCnt;
  logic [6:0] addrSr;
  logic [7:0] addrFull;
  logic       sclRise, sclFall, startSeen, stopSeen, addrHit;

  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startSeen = sclS & sclD & sdaD & ~sdaS;
  assign stopSeen  = sclS & sclD & ~sdaD & sdaS;
  assign addrFull  = {addrSr, sdaS};
  assign addrHit   = (addrFull[7:1] == {BASE_ADDR, addrSel}) & addrFull[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      addrSr <= '0;
    end else if (startSeen) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
    end else if (stopSeen) begin
      state  <= ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR: if (sclRise) begin
          addrSr <= addrFull[6:0];
          bitCnt <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) state <= addrHit ? ST_PREACK : ST_IDLE;
        end
        ST_PREACK: if (sclFall) state <= ST_ACK;
        ST_ACK, ST_RELOAD: if (sclFall) begin
          state  <= ST_SEND;
          bitCnt <= '0;
        end
        ST_SEND: if (sclFall) begin
          if (bitCnt == 3'd7) state <= ST_MACK;
          else bitCnt <= bitCnt + 3'd1;
        end
        ST_MACK: if (sclRise) state <= sdaS ? ST_IDLE : ST_RELOAD;
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.load   = sclFall & ((state == ST_ACK) | (state == ST_RELOAD));
    strb.shift  = sclFall & (state == ST_SEND) & (bitCnt != 3'd7);
    strb.clrPor = sclRise & (state == ST_MACK) & sdaS;
  end

  assign sdaPullLow = (state == ST_ACK) | ((state == ST_SEND) & ~bitOut);

  // R3
  pull_only_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclS);
  // R8
  idle_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaPullLow);
  // R7
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.shift, strb.clrPor}));
  // R9
  start_restarts_chk: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> (state == ST_ADDR));
endmodule

// File: rtl/tuner_rd_data.sv
module tuner_rd_data
  import tuner_rd_pkg::*;
#(
  parameter int ADC_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic             inLock,
  input  logic             autoMode,
  input  logic [ADC_W-1:0] adcCode,
  output logic             bitOut
);
  localparam int BYTE_W = 8;
  localparam int RSV_W  = BYTE_W - 3 - ADC_W;
  localparam logic [RSV_W-1:0] RSV_PAT = {1'b1, {(RSV_W-1){1'b0}}};

  logic              porFlag;
  logic [BYTE_W-1:0] shiftReg;
  logic              pumpFlag;

  assign pumpFlag = ~(autoMode & inLock);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) porFlag <= 1'b1;
    else if (strb.clrPor) porFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '1;
    else if (strb.load) shiftReg <= {porFlag, inLock, pumpFlag, RSV_PAT, adcCode};
    else if (strb.shift) shiftReg <= {shiftReg[BYTE_W-2:0], 1'b1};
  end

  assign bitOut = shiftReg[BYTE_W-1];

  // R6
  por_sticky_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !porFlag |=> !porFlag);
  // R4
  reserved_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (shiftReg[ADC_W +: RSV_W] == RSV_PAT));
endmodule

// File: rtl/tuner_status_reader.sv
module tuner_status_reader
  import tuner_rd_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] BASE_ADDR   = 5'b11000,
  parameter int         ADC_W       = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             scl,
  input  logic             sdaIn,
  output logic             sdaPullLow,
  input  logic [1:0]       addrSel,
  input  logic             inLock,
  input  logic             autoMode,
  input  logic [ADC_W-1:0] adcCode
);
  logic [1:0] busSync;
  logic       bitOut;
  dpStrobe_t  strb;

  tuner_rd_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) i_sync (
    .clk(clk), .rstN(rstN), .asyncIn({scl, sdaIn}), .syncOut(busSync)
  );

  tuner_rd_ctrl #(.BASE_ADDR(BASE_ADDR)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclS(busSync[1]), .sdaS(busSync[0]),
    .addrSel(addrSel), .bitOut(bitOut), .strb(strb), .sdaPullLow(sdaPullLow)
  );

  tuner_rd_data #(.ADC_W(ADC_W)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .inLock(inLock),
    .autoMode(autoMode), .adcCode(adcCode), .bitOut(bitOut)
  );
endmodule

// File: tb/test_tuner_status_reader.sv
module test_tuner_status_reader;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaPullLow;
  logic [1:0] addrSel = 2'd2;
  logic inLock = 1'b0, autoMode = 1'b0;
  logic [2:0] adcCode = 3'd0;
  logic sdaLine;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  assign sdaLine = sdaM & ~sdaPullLow;
  always #5 clk = ~clk;

  tuner_status_reader i_tuner_status_reader (
    .clk(clk), .rstN(rstN), .scl(sclM), .sdaIn(sdaLine), .sdaPullLow(sdaPullLow),
    .addrSel(addrSel), .inLock(inLock), .autoMode(autoMode), .adcCode(adcCode)
  );

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(1); sclM = 1'b1; waitQ(1); sdaM = 1'b0; waitQ(1); sclM = 1'b0; waitQ(1);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(1); sclM = 1'b1; waitQ(1); sdaM = 1'b1; waitQ(1);
  endtask

  task automatic putBit(input logic b);
    sdaM = b; waitQ(1); sclM = 1'b1; waitQ(2); sclM = 1'b0; waitQ(1);
  endtask

  task automatic getBit(output logic b);
    sdaM = 1'b1; waitQ(1); sclM = 1'b1; waitQ(1); b = sdaLine; waitQ(1); sclM = 1'b0; waitQ(1);
  endtask

  task automatic sendAddr(input logic [7:0] a, output logic ackd);
    logic b;
    for (int i = 7; i >= 0; i--) putBit(a[i]);
    getBit(b);
    ackd = ~b;
  endtask

  task automatic getByte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) getBit(v[i]);
  endtask

  function automatic logic [7:0] expStatus(input logic por, input logic lk,
                                           input logic au, input logic [2:0] code);
    return {por, lk, ~(lk & au), 1'b1, 1'b0, code};
  endfunction

  initial begin
    repeat (2000 * 100) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ackd;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    waitQ(2);
    check("R8 reset release", {7'd0, sdaPullLow}, 8'd0);

    // R1 R6 R7: multi-byte read, POR held across acked bytes and STOP
    addrSel = 2'd2; inLock = 1'b1; autoMode = 1'b0; adcCode = 3'd5;
    busStart(); sendAddr({5'b11000, 2'd2, 1'b1}, ackd);
    check("R1 ack", {7'd0, ackd}, 8'd1);
    getByte(v);
    check("R4 R6 byte1", v, expStatus(1'b1, 1'b1, 1'b0, 3'd5));
    autoMode = 1'b1; adcCode = 3'd2;
    putBit(1'b0);
    getByte(v);
    check("R7 fresh byte2", v, expStatus(1'b1, 1'b1, 1'b1, 3'd2));
    putBit(1'b0);
    busStop();
    busStart(); sendAddr({5'b11000, 2'd2, 1'b1}, ackd);
    getByte(v);
    check("R6 STOP keeps flag", v, expStatus(1'b1, 1'b1, 1'b1, 3'd2));
    putBit(1'b1);
    waitQ(1);
    check("R8 release after nack", {7'd0, sdaPullLow}, 8'd0);
    busStop();
    busStart(); sendAddr({5'b11000, 2'd2, 1'b1}, ackd);
    getByte(v);
    check("R6 flag cleared", v, expStatus(1'b0, 1'b1, 1'b1, 3'd2));
    putBit(1'b1); busStop();

    // R10 R1 R2: select code versus address low bits, both directions
    inLock = 1'b0; autoMode = 1'b0; adcCode = 3'd6;
    for (int s = 0; s < 4; s++) begin
      for (int lo = 0; lo < 4; lo++) begin
        for (int rw = 0; rw < 2; rw++) begin
          addrSel = 2'(s);
          busStart(); sendAddr({5'b11000, 2'(lo), 1'(rw)}, ackd);
          check($sformatf("R10 R2 sel%0d lo%0d rw%0d ack", s, lo, rw), {7'd0, ackd},
                {7'd0, (s == lo) && (rw == 1)});
          getByte(v);
          check($sformatf("R2 R3 sel%0d lo%0d rw%0d data", s, lo, rw), v,
                ((s == lo) && (rw == 1)) ? expStatus(1'b0, 1'b0, 1'b0, 3'd6) : 8'hFF);
          putBit(1'b1); busStop();
        end
      end
    end

    // R4 R5 R3: all code / lock / auto combinations
    addrSel = 2'd1;
    for (int k = 0; k < 32; k++) begin
      adcCode = 3'(k); inLock = k[3]; autoMode = k[4];
      busStart(); sendAddr({5'b11000, 2'd1, 1'b1}, ackd);
      getByte(v);
      check($sformatf("R5 R4 combo %0d", k), v, expStatus(1'b0, k[3], k[4], 3'(k)));
      putBit(1'b1); busStop();
    end

    // R9: repeated START in the middle of an address
    inLock = 1'b1; autoMode = 1'b1; adcCode = 3'd3;
    busStart();
    for (int i = 0; i < 4; i++) putBit(1'b0);
    busStart(); sendAddr({5'b11000, 2'd1, 1'b1}, ackd);
    check("R9 restart ack", {7'd0, ackd}, 8'd1);
    getByte(v);
    check("R9 restart data", v, expStatus(1'b0, 1'b1, 1'b1, 3'd3));
    putBit(1'b1); busStop();

    // R9: STOP mid-address, later address without START is ignored
    busStart();
    for (int i = 0; i < 3; i++) putBit(1'b1);
    busStop();
    sclM = 1'b0; waitQ(1);
    sendAddr({5'b11000, 2'd1, 1'b1}, ackd);
    check("R9 stop to idle", {7'd0, ackd}, 8'd0);
    getByte(v);
    check("R9 idle data released", v, 8'hFF);
    busStop();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule